// File: doc/BRIEF.md
# Staged-Write Line Lookup Table

This block stores the per-line mapping table consulted by a display-oriented address translator. Each of the 1024 lines owns a 35-bit entry: a line-enable flag, the numbers of the first and last mapped 16-byte blocks of the line, and an 18-bit line offset. A 35-bit entry does not fit in one 32-bit bus word, so software sees every entry as two word locations, a low word with the enable and block limits and a high word with the offset.

Writing a low word only fills a holding register. The following high-word write combines the held fields with the new offset and stores the whole entry in one step, so the translator never sees half of an update. The single table port is shared by the register port and the translator's lookup port: a committing high-word write beats a lookup, and a lookup beats a register read. Both ports return data one cycle after their request is accepted. The lookup port uses a valid/ready handshake. The register port holds its request and sees a wait signal while the request is refused.

Top module: `staged_line_table`

## Requirements
- R1: Entry x sits at byte address 0x1000 + 8*x for its low word and 0x1000 + 8*x + 4 for its high word, for x from 0 to 1023. A write outside that range changes nothing, including the holding register. A read outside it returns zero.
- R2: A low-word write loads only the holding register. Reads and lookups of the table return the old entry until a high-word write commits.
- R3: A high-word write stores the held enable and block limits together with the offset from bits 21:4 of the write data. The combined entry goes to the line addressed by the high-word write, whichever line the earlier low write addressed.
- R4: A low-word read returns the stored entry: enable in bit 0, first valid block in bits 15:8 and last valid block in bits 23:16, with every other bit zero even if it was written as one.
- R5: A high-word read returns the line offset in bits 21:4, with bits 31:22 and 3:0 zero.
- R6: After reset every entry is zero, so every line is disabled, and no response or wait is pending.
- R7: Register writes never wait. A high-word write in the same cycle as a lookup request drops lookup ready, and the lookup is then served with the newly written entry.
- R8: A low-word write does not stall a lookup in the same cycle.
- R9: A register read presented with a lookup request waits (wait high) until no lookup is requested. At most one response of either kind appears per cycle.
- R10: A lookup accepted at a clock edge returns the entry fields (enable, first block, last block, offset) with response valid in the next cycle. Back-to-back lookups stream one per cycle.
- R11: A register read accepted at a clock edge returns its data with read valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regReq | input | 1 | Register access request, held until accepted |
| regWe | input | 1 | 1 = write, 0 = read |
| regAddr | input | 14 | Byte address of the word |
| regWdata | input | 32 | Write data |
| regWait | output | 1 | Read request refused this cycle |
| regRvalid | output | 1 | Read data valid |
| regRdata | output | 32 | Read data |
| lkValid | input | 1 | Lookup request |
| lkLine | input | 10 | Line index to look up |
| lkReady | output | 1 | Lookup accepted when high with lkValid |
| lkRespValid | output | 1 | Lookup result valid |
| lkEnable | output | 1 | Line enable of the looked-up entry |
| lkFirst | output | 8 | First valid block |
| lkLast | output | 8 | Last valid block |
| lkOffset | output | 18 | Line offset (bits 21:4 of the byte offset) |

## Verification
The hardest cases to reach are the collisions on the shared table port. One is a committing high-word write landing on the same edge as a lookup of that same line. The other is a register read arriving while the translator keeps a lookup request up. The stimulus drives both ports from one process at the same falling edge. It checks lookup ready or the wait signal before the next rising edge, then queues the expected responses in the order the priority rules give. A second subtle case is a low write to one line followed by a high write to another, which shows that the held fields go wherever the high write points.

// File: rtl/lut_stage_pkg.sv
package lut_stage_pkg;

  parameter int BLK_W  = 8;
  parameter int OFS_W  = 18;
  parameter int WORD_W = 32;

  // bit positions inside the two bus words
  parameter int EN_BIT    = 0;
  parameter int FIRST_LSB = 8;
  parameter int LAST_LSB  = 16;
  parameter int OFS_LSB   = 4;

  typedef struct packed {
    logic             enable;
    logic [BLK_W-1:0] firstBlk;
    logic [BLK_W-1:0] lastBlk;
  } lowFields_t;

  typedef struct packed {
    lowFields_t       low;
    logic [OFS_W-1:0] lineOfs;
  } lineEntry_t;

  localparam int ENTRY_W = $bits(lineEntry_t);

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic holdLoad;   // capture low fields into holding register
    logic ramWrite;   // commit held fields plus offset
    logic ramRead;    // read the table into the response register
    logic cpuRead;    // the response belongs to the register port
    logic readHigh;   // register read targets the high word
    logic readVoid;   // register read outside the table range
  } lutStrobe_t;

endpackage

// File: rtl/line_table_ctrl.sv
module line_table_ctrl
  import lut_stage_pkg::*;
#(
  parameter int          LINES      = 1024,
  parameter int          REG_ADDR_W = 14,
  parameter logic [31:0] BASE_ADDR  = 32'h1000,
  localparam int         IDX_W      = $clog2(LINES)
) (
  input  logic                  regReq,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  lkValid,
  input  logic [IDX_W-1:0]      lkLine,
  output logic                  lkReady,
  output logic                  regWait,
  output lutStrobe_t            strobe,
  output logic [IDX_W-1:0]      ramIdx
);

  localparam logic [31:0] SPAN_END = BASE_ADDR + 32'(LINES) * 32'd8;

  logic [31:0]            addrWide;
  logic [REG_ADDR_W-1:0]  relAddr;
  logic                   inRange;
  logic                   isHigh;
  logic [IDX_W-1:0]       lineIdx;
  logic                   wrReq, rdReq;
  logic                   wrHigh, wrLow;
  logic                   lkTake, rdTake;
  logic                   relUnused;

  assign addrWide = 32'(regAddr);
  assign relAddr  = regAddr - BASE_ADDR[REG_ADDR_W-1:0];
  assign inRange  = (addrWide >= BASE_ADDR) && (addrWide < SPAN_END);
  assign isHigh   = relAddr[2];
  assign lineIdx  = relAddr[3 +: IDX_W];
  assign relUnused = ^{relAddr[1:0], relAddr[REG_ADDR_W-1 -: (REG_ADDR_W-3-IDX_W)]};

  assign wrReq  = regReq & regWe;
  assign rdReq  = regReq & ~regWe;
  assign wrHigh = wrReq & inRange & isHigh;
  assign wrLow  = wrReq & inRange & ~isHigh;

  // a committing write owns the table; a low write does not touch it
  assign lkReady = ~wrHigh;
  assign lkTake  = lkValid & lkReady;

  // a lookup request always beats a register read
  assign regWait = rdReq & lkValid;
  assign rdTake  = rdReq & ~lkValid;

  always_comb begin
    strobe.holdLoad = wrLow;
    strobe.ramWrite = wrHigh;
    strobe.ramRead  = lkTake | (rdTake & inRange);
    strobe.cpuRead  = rdTake;
    strobe.readHigh = isHigh;
    strobe.readVoid = ~inRange;
    ramIdx          = lkTake ? lkLine : lineIdx;
  end

endmodule

// File: rtl/line_table_dp.sv
module line_table_dp
  import lut_stage_pkg::*;
#(
  parameter int  LINES = 1024,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lutStrobe_t        strobe,
  input  logic [IDX_W-1:0]  ramIdx,
  input  logic [WORD_W-1:0] regWdata,
  output logic              regRvalid,
  output logic [WORD_W-1:0] regRdata,
  output logic              lkRespValid,
  output lineEntry_t        lkEntry
);

  lowFields_t holdReg;
  lineEntry_t table_q [LINES];
  lineEntry_t rdEntry;
  lineEntry_t newEntry;
  logic       rdValid, rdCpu, rdHigh, rdVoid;
  logic       wdUnused;

  assign wdUnused = ^{regWdata[WORD_W-1:LAST_LSB+BLK_W], regWdata[FIRST_LSB-1:EN_BIT+1],
                      regWdata[OFS_LSB-1:0]};

  assign newEntry = '{low: holdReg, lineOfs: regWdata[OFS_LSB +: OFS_W]};

  // holding register for the low half of an entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobe.holdLoad) begin
      holdReg.enable   <= regWdata[EN_BIT];
      holdReg.firstBlk <= regWdata[FIRST_LSB +: BLK_W];
      holdReg.lastBlk  <= regWdata[LAST_LSB +: BLK_W];
    end
  end

  // table storage, one entry written per commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) table_q[i] <= '0;
    end else if (strobe.ramWrite) begin
      table_q[ramIdx] <= newEntry;
    end
  end

  // single read register shared by both consumers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEntry <= '0;
      rdValid <= 1'b0;
      rdCpu   <= 1'b0;
      rdHigh  <= 1'b0;
      rdVoid  <= 1'b0;
    end else begin
      if (strobe.ramRead) rdEntry <= table_q[ramIdx];
      rdValid <= strobe.ramRead | strobe.cpuRead;
      rdCpu   <= strobe.cpuRead;
      rdHigh  <= strobe.readHigh;
      rdVoid  <= strobe.readVoid;
    end
  end

  assign regRvalid   = rdValid & rdCpu;
  assign lkRespValid = rdValid & ~rdCpu;
  assign lkEntry     = rdEntry;

  always_comb begin
    regRdata = '0;
    if (!rdVoid) begin
      if (rdHigh) begin
        regRdata[OFS_LSB +: OFS_W] = rdEntry.lineOfs;
      end else begin
        regRdata[EN_BIT]              = rdEntry.low.enable;
        regRdata[FIRST_LSB +: BLK_W]  = rdEntry.low.firstBlk;
        regRdata[LAST_LSB +: BLK_W]   = rdEntry.low.lastBlk;
      end
    end
  end

endmodule

// File: rtl/staged_line_table.sv
module staged_line_table
  import lut_stage_pkg::*;
#(
  parameter int          LINES      = 1024,
  parameter int          REG_ADDR_W = 14,
  parameter logic [31:0] BASE_ADDR  = 32'h1000,
  localparam int         IDX_W      = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regReq,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWdata,
  output logic                  regWait,
  output logic                  regRvalid,
  output logic [31:0]           regRdata,
  input  logic                  lkValid,
  input  logic [IDX_W-1:0]      lkLine,
  output logic                  lkReady,
  output logic                  lkRespValid,
  output logic                  lkEnable,
  output logic [7:0]            lkFirst,
  output logic [7:0]            lkLast,
  output logic [17:0]           lkOffset
);

  lutStrobe_t       strobe;
  logic [IDX_W-1:0] ramIdx;
  lineEntry_t       lkEntry;

  line_table_ctrl #(
    .LINES(LINES), .REG_ADDR_W(REG_ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .regReq (regReq),
    .regWe  (regWe),
    .regAddr(regAddr),
    .lkValid(lkValid),
    .lkLine (lkLine),
    .lkReady(lkReady),
    .regWait(regWait),
    .strobe (strobe),
    .ramIdx (ramIdx)
  );

  line_table_dp #(.LINES(LINES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ramIdx     (ramIdx),
    .regWdata   (regWdata),
    .regRvalid  (regRvalid),
    .regRdata   (regRdata),
    .lkRespValid(lkRespValid),
    .lkEntry    (lkEntry)
  );

  assign lkEnable = lkEntry.low.enable;
  assign lkFirst  = lkEntry.low.firstBlk;
  assign lkLast   = lkEntry.low.lastBlk;
  assign lkOffset = lkEntry.lineOfs;

endmodule

// File: rtl/staged_line_table_chk.sv
module staged_line_table_chk (
  input logic clk,
  input logic rstN,
  input logic regReq,
  input logic regWe,
  input logic regWait,
  input logic regRvalid,
  input logic lkValid,
  input logic lkReady,
  input logic lkRespValid
);

  assert_write_beats_lookup_R7: assert property (@(posedge clk) disable iff (!rstN)
    !lkReady |-> (regReq && regWe));

  assert_read_waits_R9: assert property (@(posedge clk) disable iff (!rstN)
    regWait |-> (lkValid && regReq && !regWe));

  assert_single_response_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(lkRespValid && regRvalid));

  assert_lookup_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady) |=> lkRespValid);

  assert_lookup_origin_R10: assert property (@(posedge clk) disable iff (!rstN)
    lkRespValid |-> $past(lkValid && lkReady));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regWe && !regWait) |=> regRvalid);

endmodule

bind staged_line_table staged_line_table_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regReq     (regReq),
  .regWe      (regWe),
  .regWait    (regWait),
  .regRvalid  (regRvalid),
  .lkValid    (lkValid),
  .lkReady    (lkReady),
  .lkRespValid(lkRespValid)
);

// File: tb/staged_line_table_tb.sv
`timescale 1ns/1ps
module staged_line_table_tb;

  localparam int LINES = 1024;
  localparam int BASE  = 32'h1000;
  localparam real CLK_NS = 4.0;

  logic        clk = 0;
  logic        rstN = 0;
  logic        regReq = 0, regWe = 0;
  logic [13:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regWait, regRvalid;
  logic [31:0] regRdata;
  logic        lkValid = 0;
  logic [9:0]  lkLine = '0;
  logic        lkReady, lkRespValid, lkEnable;
  logic [7:0]  lkFirst, lkLast;
  logic [17:0] lkOffset;

  always #(CLK_NS/2) clk = ~clk;

  staged_line_table u_dut (.*);

  typedef struct { bit isCpu; logic [34:0] val; string tag; } expItem_t;
  expItem_t expQ[$];

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model: entry = {enable, first, last, offset}
  logic [34:0] mdl [LINES];
  logic [16:0] hold = '0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] expLow(int x);
    return {8'h0, mdl[x][25:18], mdl[x][33:26], 7'h0, mdl[x][34]};
  endfunction
  function automatic logic [31:0] expHigh(int x);
    return {10'h0, mdl[x][17:0], 4'h0};
  endfunction
  function automatic bit inRange(int a);
    return (a >= BASE) && (a < BASE + 8*LINES);
  endfunction
  function automatic logic [31:0] expRead(int a);
    if (!inRange(a)) return 32'h0;
    return ((a - BASE) & 4) ? expHigh((a - BASE) >> 3) : expLow((a - BASE) >> 3);
  endfunction

  function automatic void modelWrite(int a, logic [31:0] d);
    if (inRange(a)) begin
      if ((a - BASE) & 4) mdl[(a - BASE) >> 3] = {hold, d[21:4]};
      else hold = {d[0], d[15:8], d[23:16]};
    end
  endfunction

  function automatic void pushExp(bit isCpu, logic [34:0] v, string tag);
    expItem_t it;
    it.isCpu = isCpu; it.val = v; it.tag = tag;
    expQ.push_back(it);
  endfunction

  // monitor: compare every response against the scoreboard
  task automatic popCmp(bit isCpu, logic [34:0] got);
    expItem_t it;
    checks++;
    if (expQ.size() == 0) begin
      failures++;
      $display("FAIL R10/R11 unexpected response: actual %h expected none", got);
    end else begin
      it = expQ.pop_front();
      if (it.isCpu != isCpu || it.val !== got) begin
        failures++;
        $display("FAIL %s: actual %0d:%h expected %0d:%h", it.tag, isCpu, got, it.isCpu, it.val);
      end
    end
  endtask

  always @(negedge clk) if (rstN) begin
    if (regRvalid)   popCmp(1'b1, {3'b0, regRdata});
    if (lkRespValid) popCmp(1'b0, {lkEnable, lkFirst, lkLast, lkOffset});
  end

  task automatic wrWord(int a, logic [31:0] d);
    @(negedge clk);
    regReq = 1; regWe = 1; regAddr = 14'(a); regWdata = d;
    #1 chk("R7 write wait", {63'b0, regWait}, 64'd0);
    modelWrite(a, d);
    @(negedge clk);
    regReq = 0; regWe = 0;
  endtask

  task automatic rdWord(int a, string tag);
    @(negedge clk);
    regReq = 1; regWe = 0; regAddr = 14'(a);
    #1;
    while (regWait) begin @(negedge clk); #1; end
    pushExp(1'b1, {3'b0, expRead(a)}, tag);
    @(negedge clk);
    regReq = 0;
  endtask

  task automatic lookup(int line, string tag);
    @(negedge clk);
    lkValid = 1; lkLine = 10'(line);
    #1;
    while (!lkReady) begin @(negedge clk); #1; end
    pushExp(1'b0, mdl[line], tag);
    @(negedge clk);
    lkValid = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < LINES; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R6: idle outputs and cleared entries
    chk("R6 regRvalid", {63'b0, regRvalid}, 0);
    chk("R6 lkRespValid", {63'b0, lkRespValid}, 0);
    chk("R6 regWait", {63'b0, regWait}, 0);
    rdWord(BASE, "R6 low entry 0");
    rdWord(BASE + 8*1023 + 4, "R6 high entry 1023");
    lookup(512, "R6 lookup 512");

    // R2: low write alone changes nothing visible
    wrWord(BASE + 8*5, 32'h009A_1201);
    rdWord(BASE + 8*5, "R2 low after low write");
    lookup(5, "R2 lookup after low write");

    // R3, R4, R5: commit and read back both words
    wrWord(BASE + 8*5 + 4, 32'h003F_FF90);
    rdWord(BASE + 8*5, "R4 low field layout");
    rdWord(BASE + 8*5 + 4, "R5 high field layout");
    lookup(5, "R3 lookup after commit");

    // R3: held fields go to the line of the high write
    wrWord(BASE + 8*7, 32'h0044_3301);
    wrWord(BASE + 8*9 + 4, 32'h0000_0040);
    lookup(9, "R3 commit into high-write line");
    rdWord(BASE + 8*7, "R3 low-write line untouched");

    // R4, R5: reserved bits read as zero, last entry
    wrWord(BASE + 8*1023, 32'hFFFF_FFFF);
    wrWord(BASE + 8*1023 + 4, 32'hFFFF_FFFF);
    rdWord(BASE + 8*1023, "R4 reserved low bits zero");
    rdWord(BASE + 8*1023 + 4, "R5 reserved high bits zero");
    chk("R4 model low", {32'b0, expLow(1023)}, 64'h00FF_FF01);

    // R1: out-of-range writes ignored (hold kept), reads zero
    wrWord(BASE + 8*LINES, 32'h0011_2200);
    wrWord(BASE - 8, 32'h0033_4400);
    wrWord(BASE + 8*2 + 4, 32'h0000_1230);
    lookup(2, "R1 hold survives out-of-range write");
    rdWord(BASE + 8*LINES, "R1 read above range");
    rdWord(BASE - 4, "R1 read below range");

    // R7: high write collides with lookup of same line
    wrWord(BASE + 8*20, 32'h0077_1101);
    @(negedge clk);
    regReq = 1; regWe = 1; regAddr = 14'(BASE + 8*20 + 4); regWdata = 32'h0000_5550;
    lkValid = 1; lkLine = 10'd20;
    #1 chk("R7 lkReady low on commit", {63'b0, lkReady}, 0);
    modelWrite(BASE + 8*20 + 4, 32'h0000_5550);
    @(negedge clk);
    regReq = 0; regWe = 0;
    #1 chk("R7 lkReady after commit", {63'b0, lkReady}, 1);
    pushExp(1'b0, mdl[20], "R7 lookup sees new entry");
    @(negedge clk);
    lkValid = 0;

    // R8: low write does not stall a lookup
    @(negedge clk);
    regReq = 1; regWe = 1; regAddr = 14'(BASE + 8*21); regWdata = 32'h0066_0501;
    lkValid = 1; lkLine = 10'd21;
    #1 chk("R8 lkReady during low write", {63'b0, lkReady}, 1);
    pushExp(1'b0, mdl[21], "R8 lookup during low write");
    modelWrite(BASE + 8*21, 32'h0066_0501);
    @(negedge clk);
    regReq = 0; regWe = 0; lkValid = 0;
    rdWord(BASE + 8*21, "R2 low write still pending");

    // R9: lookup beats register read
    @(negedge clk);
    regReq = 1; regWe = 0; regAddr = 14'(BASE + 8*20);
    lkValid = 1; lkLine = 10'd5;
    #1 chk("R9 read waits for lookup", {63'b0, regWait}, 1);
    pushExp(1'b0, mdl[5], "R9 lookup served first");
    @(negedge clk);
    lkValid = 0;
    #1 chk("R9 wait released", {63'b0, regWait}, 0);
    pushExp(1'b1, {3'b0, expLow(20)}, "R11 read after lookup");
    @(negedge clk);
    regReq = 0;

    // R10: streaming lookups one per cycle
    @(negedge clk);
    foreach (mdl[i]) if (i == 5 || i == 9 || i == 1023 || i == 2 || i == 20) begin
      lkValid = 1; lkLine = 10'(i);
      #1 pushExp(1'b0, mdl[i], "R10 streamed lookup");
      @(negedge clk);
    end
    lkValid = 0;

    repeat (4) @(negedge clk);
    chk("R10/R11 all responses delivered", 64'(expQ.size()), 0);
    finishRun();
  end

endmodule